// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

The block holds two 8-bit counting channels that can be run either on their own or chained into a single 16-bit interval timer. In chained mode the low channel counts on a selectable prescaled clock enable, and every time it rolls over from its all-ones value the high channel advances by one. When both channels sit on their compare values together, both clear to zero on the next count tick, counting carries on, and a one-cycle interrupt pulse is raised on the high channel's line. The result is a repeating interval of (N+1) count ticks, where N is the 16-bit value split across the two compare registers.

Software sets the block up through a small write-only register port: a control register with a run bit and a chain bit, a clock-select register, and one compare register per channel. The count rate is a single-cycle enable derived from the system clock by a power-of-two divider, so the whole block stays in one clock domain. A toggle output flips on every interrupt and gives a square wave whose half-period is the interval. With the chain bit cleared, each channel wraps at its own compare value and raises its own interrupt.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counts, both interrupt lines and the toggle output are 0.
- R2: Register map at wr_addr: 0 = control (bit 0 run, bit 1 chain), 1 = clock select (bits 3:0), 2 = low compare, 3 = high compare. With chain=1 and run=1 the 16-bit count {count_hi,count_lo} steps 0, 1, ... N and then back to 0, one step per count tick, for any N from 0x0000 to 0xFFFF held as {high compare, low compare}.
- R3: In chained mode, when count_lo is 0xFF and the pair is not on its compare values, the next tick sets count_lo to 0 and raises count_hi by one.
- R4: At the tick that clears the pair, irq_hi is high for exactly that following cycle; it is high in no other cycle of chained operation.
- R5: tout inverts in each cycle in which irq_hi is high and is 0 from the first cycle after run is cleared.
- R6: A clock-select code k from 0 to 7 gives one count tick every 2^k system clocks, the first tick landing on the 2^k-th rising edge after the edge that sets run.
- R7: Clock-select codes 8 to 15 give no count ticks; the counts hold their values.
- R8: Clearing run sets both counts to 0 at the next edge; setting run again restarts the sequence from 0.
- R9: With chain=0, each channel counts on every tick, wraps from its own compare value to 0, and raises its own interrupt (irq_lo for the low channel, irq_hi for the high one) for one cycle at that wrap; tout follows irq_hi.
- R10: irq_lo never goes high while chain=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data |
| count_lo | output | 8 | Low channel count |
| count_hi | output | 8 | High channel count |
| irq_lo | output | 1 | Low channel interrupt pulse (independent mode only) |
| irq_hi | output | 1 | High channel / chained pair interrupt pulse |
| tout | output | 1 | Toggle output, flips on each irq_hi |

## Verification
The assertions assume that a write to the control or clock-select register is the only way the run state and tick rate change, and that the compare registers are not rewritten while the pair is part-way through a chained interval, since the clear-at-match property then looks at a count that may have stepped past its compare. The stimulus keeps to this by loading clock select and both compares with run cleared, then setting run, and only touching the registers again to stop a run or to switch to a stopping clock-select code. Random runs draw the interval and the divider code from a seeded generator; directed runs cover N=0, the low-byte rollover, the full 16-bit interval and the stopping codes.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_CLKSEL = 2'd1,
    REG_CMP_LO = 2'd2,
    REG_CMP_HI = 2'd3
  } reg_sel_e;

  localparam int CTRL_RUN_BIT   = 0;
  localparam int CTRL_CHAIN_BIT = 1;

endpackage

// File: rtl/timer_rst_sync.sv
module timer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             run,
  output logic             chain,
  output logic [SEL_W-1:0] clk_sel,
  output logic [CNT_W-1:0] cmp_lo,
  output logic [CNT_W-1:0] cmp_hi
);

  logic             run_d, chain_d;
  logic [SEL_W-1:0] sel_d;
  logic [CNT_W-1:0] cmp_lo_d, cmp_hi_d;
  reg_sel_e         sel_reg;

  assign sel_reg = reg_sel_e'(wr_addr);

  always_comb begin
    run_d    = run;
    chain_d  = chain;
    sel_d    = clk_sel;
    cmp_lo_d = cmp_lo;
    cmp_hi_d = cmp_hi;
    if (wr_en) begin
      unique case (sel_reg)
        REG_CTRL: begin
          run_d   = wr_data[CTRL_RUN_BIT];
          chain_d = wr_data[CTRL_CHAIN_BIT];
        end
        REG_CLKSEL: sel_d    = wr_data[SEL_W-1:0];
        REG_CMP_LO: cmp_lo_d = wr_data;
        REG_CMP_HI: cmp_hi_d = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      chain   <= 1'b0;
      clk_sel <= '0;
      cmp_lo  <= '0;
      cmp_hi  <= '0;
    end else begin
      run     <= run_d;
      chain   <= chain_d;
      clk_sel <= sel_d;
      cmp_lo  <= cmp_lo_d;
      cmp_hi  <= cmp_hi_d;
    end
  end

endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int SEL_W      = 4,
  parameter int DIV_STAGES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] clk_sel,
  output logic             tick
);

  localparam int PRE_W = (DIV_STAGES > 1) ? DIV_STAGES - 1 : 1;
  localparam int N_SEL = 1 << SEL_W;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [N_SEL-1:0] tap;

  // Divider restarts from zero whenever counting is stopped, so the first
  // tick after start lands a fixed number of cycles after the run edge.
  always_comb begin
    if (!run) pre_d = '0;
    else      pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  for (genvar g = 0; g < N_SEL; g++) begin : g_tap
    if (g == 0) begin : g_div1
      assign tap[g] = 1'b1;
    end else if (g < DIV_STAGES) begin : g_divn
      assign tap[g] = &pre_q[g-1:0];
    end else begin : g_stop
      assign tap[g] = 1'b0;
    end
  end

  assign tick = run & tap[clk_sel];

endmodule

// File: rtl/timer_channel.sv
module timer_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             at_cmp,
  output logic             at_max
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (step) cnt_d = cnt + 1'b1;
    else           cnt_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign at_cmp = (cnt == cmp);
  assign at_max = &cnt;

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
  parameter int CNT_W      = 8,
  parameter int SEL_W      = 4,
  parameter int DIV_STAGES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_lo,
  output logic [CNT_W-1:0] count_hi,
  output logic             irq_lo,
  output logic             irq_hi,
  output logic             tout
);

  logic             rst_sync_n;
  logic             run, chain, tick;
  logic [SEL_W-1:0] clk_sel;
  logic [CNT_W-1:0] cmp_lo, cmp_hi;
  logic             lo_at_cmp, lo_at_max, hi_at_cmp, hi_at_max;
  logic             pair_match;
  logic             lo_step, lo_wrap, hi_step, hi_wrap;
  logic             irq_lo_d, irq_hi_d, tout_d;

  timer_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  timer_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .run     (run),
    .chain   (chain),
    .clk_sel (clk_sel),
    .cmp_lo  (cmp_lo),
    .cmp_hi  (cmp_hi)
  );

  timer_prescaler #(.SEL_W(SEL_W), .DIV_STAGES(DIV_STAGES)) u_pre (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (run),
    .clk_sel (clk_sel),
    .tick    (tick)
  );

  timer_channel #(.CNT_W(CNT_W)) u_lo (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (run),
    .step   (lo_step),
    .wrap   (lo_wrap),
    .cmp    (cmp_lo),
    .cnt    (count_lo),
    .at_cmp (lo_at_cmp),
    .at_max (lo_at_max)
  );

  timer_channel #(.CNT_W(CNT_W)) u_hi (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (run),
    .step   (hi_step),
    .wrap   (hi_wrap),
    .cmp    (cmp_hi),
    .cnt    (count_hi),
    .at_cmp (hi_at_cmp),
    .at_max (hi_at_max)
  );

  assign pair_match = lo_at_cmp & hi_at_cmp;

  // Step and wrap decisions per mode: chained pair clears only on a joint
  // match and the high half advances on the low half's rollover.
  always_comb begin
    if (chain) begin
      lo_step  = tick;
      lo_wrap  = tick & pair_match;
      hi_step  = tick & lo_at_max;
      hi_wrap  = tick & pair_match;
      irq_lo_d = 1'b0;
      irq_hi_d = tick & pair_match;
    end else begin
      lo_step  = tick;
      lo_wrap  = tick & lo_at_cmp;
      hi_step  = tick;
      hi_wrap  = tick & hi_at_cmp;
      irq_lo_d = tick & lo_at_cmp;
      irq_hi_d = tick & hi_at_cmp;
    end
  end

  always_comb begin
    if (!run) tout_d = 1'b0;
    else      tout_d = tout ^ irq_hi_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
      tout   <= 1'b0;
    end else begin
      irq_lo <= irq_lo_d;
      irq_hi <= irq_hi_d;
      tout   <= tout_d;
    end
  end

endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
  parameter int CNT_W      = 8,
  parameter int SEL_W      = 4,
  parameter int DIV_STAGES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             chain,
  input logic             tick,
  input logic [SEL_W-1:0] clk_sel,
  input logic             pair_match,
  input logic [CNT_W-1:0] count_lo,
  input logic [CNT_W-1:0] count_hi,
  input logic             irq_lo,
  input logic             irq_hi,
  input logic             tout
);

  logic sel_stops;
  assign sel_stops = (int'(clk_sel) >= DIV_STAGES);

  // R2: counts move only on a count tick
  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick |=> $stable(count_lo) && $stable(count_hi));

  // R3: low rollover carries into the high half
  assert_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run && chain && tick && (&count_lo) && !pair_match |=>
      (count_lo == '0) && (count_hi == $past(count_hi) + 1'b1));

  // R4: chained interrupt coincides with a cleared pair
  assert_irq_at_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi && $past(chain) |-> (count_lo == '0) && (count_hi == '0));

  // R5: toggle output changes only with an interrupt while running
  assert_tout_follows_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) && !$stable(tout) |-> irq_hi);

  // R5: toggle output parked low once stopped
  assert_tout_low_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tout);

  // R7: stopping codes freeze the counts
  assert_stop_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run && sel_stops |=> $stable(count_lo) && $stable(count_hi));

  // R8: stopping clears both counts
  assert_clear_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count_lo == '0) && (count_hi == '0));

  // R10: no low interrupt in chained mode
  assert_no_lo_irq_chained_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chain |=> !irq_lo);

endmodule

bind dual_interval_timer timer_checker #(
  .CNT_W(CNT_W), .SEL_W(SEL_W), .DIV_STAGES(DIV_STAGES)
) u_timer_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .chain      (chain),
  .tick       (tick),
  .clk_sel    (clk_sel),
  .pair_match (pair_match),
  .count_lo   (count_lo),
  .count_hi   (count_hi),
  .irq_lo     (irq_lo),
  .irq_hi     (irq_hi),
  .tout       (tout)
);

// File: tb/test_dual_interval_timer.sv
`timescale 1ns/1ps
module test_dual_interval_timer;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] count_lo, count_hi;
  logic       irq_lo, irq_hi, tout;

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 0;

  dual_interval_timer i_dual_interval_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .count_lo (count_lo),
    .count_hi (count_hi),
    .irq_lo   (irq_lo),
    .irq_hi   (irq_hi),
    .tout     (tout)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Model: ticks elapsed after m edges since the run edge
  function automatic int ticks_of(int m, int k);
    if (k > 7) return 0;
    return m >> k;
  endfunction

  function automatic bit tick_edge(int m, int k);
    if (k > 7) return 0;
    return (m % (1 << k)) == 0;
  endfunction

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = addr[1:0];
    wr_data = data[7:0];
    @(posedge clk);
    #1;
    wr_en   = 1'b0;
  endtask

  task automatic stop_and_check(input int chain_bit);
    wr(0, chain_bit << 1);
    @(posedge clk); #1;
    chk("R8 count after stop", {count_hi, count_lo}, 0);
    chk("R5 tout after stop", tout, 0);
  endtask

  // Chained run: returns with the pair still running
  task automatic chained(input int k, input int n, input int cycles, input string tag);
    wr(1, k);
    wr(2, n & 8'hFF);
    wr(3, (n >> 8) & 8'hFF);
    wr(0, 2'b10);
    wr(0, 2'b11);
    for (int m = 1; m <= cycles; m++) begin
      int  t;
      int  ec;
      bit  ei;
      string ctag;
      @(posedge clk); #1;
      t    = ticks_of(m, k);
      ec   = t % (n + 1);
      ei   = tick_edge(m, k) && (t > 0) && (ec == 0);
      ctag = ((ec % 256) == 0 && ec > 0) ? "R3 carry" : tag;
      chk(ctag, {count_hi, count_lo}, ec);
      chk("R4 irq_hi", irq_hi, ei);
      chk("R5 tout", tout, (t / (n + 1)) & 1);
      chk("R10 irq_lo", irq_lo, 0);
    end
  endtask

  task automatic independent(input int k, input int cl, input int ch, input int cycles);
    wr(1, k);
    wr(2, cl);
    wr(3, ch);
    wr(0, 2'b00);
    wr(0, 2'b01);
    for (int m = 1; m <= cycles; m++) begin
      int t;
      @(posedge clk); #1;
      t = ticks_of(m, k);
      chk("R9 count_lo", count_lo, t % (cl + 1));
      chk("R9 count_hi", count_hi, t % (ch + 1));
      chk("R9 irq_lo", irq_lo, tick_edge(m, k) && t > 0 && (t % (cl + 1)) == 0);
      chk("R9 irq_hi", irq_hi, tick_edge(m, k) && t > 0 && (t % (ch + 1)) == 0);
      chk("R9 tout", tout, (t / (ch + 1)) & 1);
    end
    stop_and_check(0);
  endtask

  initial begin
    int seed_val;
    seed_val = $urandom(32'h5eed1234);
    wr_en   = 1'b0;
    wr_addr = 2'd0;
    wr_data = 8'd0;
    rst_n   = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 reset counts", {count_hi, count_lo}, 0);
    chk("R1 reset irq", {irq_hi, irq_lo}, 0);
    chk("R1 reset tout", tout, 0);

    // Directed corner cases
    chained(0, 0, 12, "R2 N=0");
    stop_and_check(1);
    chained(0, 16'h00FF, 600, "R2 N=0x00FF");
    stop_and_check(1);
    chained(0, 16'h0105, 800, "R2 N=0x0105");
    stop_and_check(1);
    chained(3, 4, 200, "R6 div8");
    stop_and_check(1);
    chained(7, 1, 700, "R6 div128");
    stop_and_check(1);
    chained(12, 5, 60, "R7 stop code");
    stop_and_check(1);

    // R7: switch to a stopping code mid-run; the write edge still counts
    chained(0, 1000, 20, "R2 pre-stop");
    wr(1, 9);
    repeat (6) @(posedge clk);
    #1;
    chk("R7 held count", {count_hi, count_lo}, 21);
    stop_and_check(1);

    // R8: restart from zero after a stop
    chained(1, 30, 100, "R8 restart");
    stop_and_check(1);

    // Full 16-bit interval
    chained(0, 16'hFFFF, 65540, "R2 N=0xFFFF");
    stop_and_check(1);

    // Constrained random chained runs
    for (int i = 0; i < 8; i++) begin
      int k, n, cyc;
      k   = $urandom % 3;
      n   = (i % 2 == 0) ? ($urandom % 40) : (250 + $urandom % 400);
      cyc = (n + 1) * (1 << k) * 2 + 7;
      if (cyc > 4000) cyc = 4000;
      chained(k, n, cyc, "R2 random");
      stop_and_check(1);
    end

    // Independent channels
    independent(0, 3, 7, 50);
    for (int i = 0; i < 4; i++) begin
      independent($urandom % 3, $urandom % 20, $urandom % 256, 600);
    end

    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

endmodule